// File: doc/BRIEF.md
# Upstream Bus Reset and Speed Negotiation Controller

This block is the state machine behind a hub's upstream port. It watches the sampled upstream line state and a timing tick, and decides what a period of SE0 means. On a full-speed port SE0 means a bus reset. On a high-speed port SE0 is normal idle, so a long stretch of it first makes the port drop back to full speed. The port then looks at the line again. If SE0 is still there, the event is a bus reset. If the line has gone back to J, the event is a suspend.

When it recognises a bus reset, the block drives its own chirp K. It then listens for the host's alternating K and J chirps. When enough of them arrive, it switches on high-speed termination and releases the full-speed pull-up. If they do not arrive within the allowed window, it falls back to the full-speed default state. All timing is counted in ticks of an external timebase, nominally 1 µs. Every window is a parameter.

Top module: `up_speed_negotiator`

## Requirements
- R1: After reset the block is in full-speed idle: fs_pullup_o=1, hs_term_o=0, chirp_k_o=0, hs_mode_o=0, bus_reset_o=0, suspend_o=0. The line encoding is 2'b00 SE0, 2'b01 J, 2'b10 K. 2'b11 counts as neither SE0 nor a chirp symbol.
- R2: In full-speed idle with suspended_i=0, SE0 held for AWAKE_RST_TICKS consecutive ticks is recognised as a bus reset: bus_reset_o pulses for one clock and chirp_k_o rises in the same clock. A shorter SE0 run that ends in a non-SE0 value has no effect.
- R3: In full-speed idle with suspended_i=1, the SE0 run needed is SUSP_SE0_TICKS ticks instead.
- R4: Timers advance only on clocks where tick_i=1. SE0 held with tick_i=0 never starts a chirp.
- R5: The block's own chirp K lasts exactly CHIRP_TICKS ticks. fs_pullup_o stays 1 throughout the chirp.
- R6: After the block's own chirp ends, a host chirp counts when the line holds the expected symbol for FILT_TICKS consecutive ticks. The expected symbol alternates, starting with K. Once the sixth chirp (three K-J pairs) counts, the block enters high speed on the next clock: hs_mode_o=1, hs_term_o=1, fs_pullup_o=0.
- R7: A host chirp held for fewer than FILT_TICKS ticks is not counted, so a sequence that contains one cannot reach high speed.
- R8: If six chirps have not counted within FALLBACK_TICKS ticks after the block's own chirp ends, the block returns to full-speed idle. Host chirps that arrive after that point are ignored.
- R9: In high speed, SE0 held for REVERT_TICKS ticks makes the block revert: hs_mode_o=0, hs_term_o=0, fs_pullup_o=1. A shorter SE0 run broken by J has no effect.
- R10: After reverting, the block samples the line SAMPLE_TICKS ticks later. If the line is SE0, bus_reset_o pulses and the chirp starts. Otherwise suspend_o pulses for one clock and the block is in full-speed idle.
- R11: hs_term_o and fs_pullup_o are never both 1. chirp_k_o is only 1 while fs_pullup_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 2 | Sampled upstream line state (00 SE0, 01 J, 10 K) |
| suspended_i | input | 1 | Port is currently suspended |
| tick_i | input | 1 | Timebase tick, one per microsecond nominal |
| chirp_k_o | output | 1 | Request to drive chirp K upstream |
| hs_term_o | output | 1 | Enable high-speed termination |
| fs_pullup_o | output | 1 | Enable full-speed pull-up |
| hs_mode_o | output | 1 | Port is operating at high speed |
| bus_reset_o | output | 1 | One-clock pulse: bus reset recognised |
| suspend_o | output | 1 | One-clock pulse: revert sample found suspend |

## Verification
SE0 runs of random length on either side of the awake and the suspended thresholds show whether the threshold is chosen by the suspend flag and whether the run must be unbroken. Host chirp sequences with random symbol lengths around the filter limit show whether short symbols are rejected and whether exactly three full pairs are needed for high speed. Directed sequences in high speed separate a reset from a suspend at the sampling point, and test the revert boundary one tick short of the limit. A chirp sequence sent after the fallback point confirms that late host chirps are ignored.

// File: rtl/up_neg_pkg.sv
package up_neg_pkg;

    typedef enum logic [1:0] {
        LN_SE0   = 2'b00,
        LN_J     = 2'b01,
        LN_K     = 2'b10,
        LN_OTHER = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        ST_FS_IDLE,
        ST_HS_IDLE,
        ST_REVERT,
        ST_CHIRP,
        ST_HOST_WAIT
    } neg_state_e;

    typedef struct packed {
        neg_state_e state;
        logic       rst_pulse;
        logic       susp_pulse;
    } neg_regs_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/up_neg_timer.sv
module up_neg_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && (cnt_q != {W{1'b1}}))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/up_neg_chirp_filter.sv
module up_neg_chirp_filter
    import up_neg_pkg::*;
#(
    parameter int FILT_TICKS = 3,
    parameter int PAIRS      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] line,
    output logic       done
);
    localparam int TOTAL = 2 * PAIRS;
    localparam int RW    = $clog2(FILT_TICKS + 1);
    localparam int NW    = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic [NW-1:0] n;
        logic          want_k;
    } filt_t;

    filt_t d, q;
    logic  sym_ok;

    always_comb begin
        d      = q;
        sym_ok = q.want_k ? (line == LN_K) : (line == LN_J);
        if (clr) begin
            d.run    = '0;
            d.n      = '0;
            d.want_k = 1'b1;
        end else if (tick && (q.n != NW'(TOTAL))) begin
            if (!sym_ok) begin
                d.run = '0;
            end else if (q.run == RW'(FILT_TICKS - 1)) begin
                d.run    = '0;
                d.n      = q.n + 1'b1;
                d.want_k = ~q.want_k;
            end else begin
                d.run = q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{run: '0, n: '0, want_k: 1'b1};
        else        q <= d;
    end

    assign done = (q.n == NW'(TOTAL));
endmodule

// File: rtl/up_speed_negotiator.sv
module up_speed_negotiator
    import up_neg_pkg::*;
#(
    parameter int AWAKE_RST_TICKS = 100,
    parameter int SUSP_SE0_TICKS  = 3,
    parameter int REVERT_TICKS    = 3050,
    parameter int SAMPLE_TICKS    = 200,
    parameter int CHIRP_TICKS     = 1500,
    parameter int FALLBACK_TICKS  = 2000,
    parameter int FILT_TICKS      = 3,
    parameter int CHIRP_PAIRS     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_i,
    input  logic       suspended_i,
    input  logic       tick_i,
    output logic       chirp_k_o,
    output logic       hs_term_o,
    output logic       fs_pullup_o,
    output logic       hs_mode_o,
    output logic       bus_reset_o,
    output logic       suspend_o
);
    localparam int MAXT = max2(max2(max2(AWAKE_RST_TICKS, SUSP_SE0_TICKS),
                                    max2(REVERT_TICKS, SAMPLE_TICKS)),
                               max2(CHIRP_TICKS, FALLBACK_TICKS));
    localparam int TW = $clog2(MAXT + 1);

    neg_regs_t     d, q;
    logic          tmr_clr;
    logic [TW-1:0] tim;
    logic [TW-1:0] fs_lim;
    logic          se0;
    logic          filt_done;

    up_neg_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tick_i),
        .count (tim)
    );

    up_neg_chirp_filter #(
        .FILT_TICKS (FILT_TICKS),
        .PAIRS      (CHIRP_PAIRS)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q.state != ST_HOST_WAIT),
        .tick  (tick_i),
        .line  (line_i),
        .done  (filt_done)
    );

    always_comb begin
        d            = q;
        d.rst_pulse  = 1'b0;
        d.susp_pulse = 1'b0;
        tmr_clr      = 1'b0;
        se0          = (line_i == LN_SE0);
        fs_lim       = suspended_i ? TW'(SUSP_SE0_TICKS - 1) : TW'(AWAKE_RST_TICKS - 1);

        case (q.state)
            ST_FS_IDLE: begin
                if (!se0) begin
                    tmr_clr = 1'b1;
                end else if (tick_i && (tim >= fs_lim)) begin
                    d.state     = ST_CHIRP;
                    d.rst_pulse = 1'b1;
                end
            end
            ST_HS_IDLE: begin
                if (!se0)
                    tmr_clr = 1'b1;
                else if (tick_i && (tim >= TW'(REVERT_TICKS - 1)))
                    d.state = ST_REVERT;
            end
            ST_REVERT: begin
                if (tick_i && (tim >= TW'(SAMPLE_TICKS - 1))) begin
                    if (se0) begin
                        d.state     = ST_CHIRP;
                        d.rst_pulse = 1'b1;
                    end else begin
                        d.state      = ST_FS_IDLE;
                        d.susp_pulse = 1'b1;
                    end
                end
            end
            ST_CHIRP: begin
                if (tick_i && (tim >= TW'(CHIRP_TICKS - 1)))
                    d.state = ST_HOST_WAIT;
            end
            ST_HOST_WAIT: begin
                if (filt_done)
                    d.state = ST_HS_IDLE;
                else if (tick_i && (tim >= TW'(FALLBACK_TICKS - 1)))
                    d.state = ST_FS_IDLE;
            end
            default: d.state = ST_FS_IDLE;
        endcase

        if (d.state != q.state)
            tmr_clr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{state: ST_FS_IDLE, rst_pulse: 1'b0, susp_pulse: 1'b0};
        else        q <= d;
    end

    assign chirp_k_o   = (q.state == ST_CHIRP);
    assign hs_term_o   = (q.state == ST_HS_IDLE);
    assign hs_mode_o   = (q.state == ST_HS_IDLE);
    assign fs_pullup_o = (q.state != ST_HS_IDLE);
    assign bus_reset_o = q.rst_pulse;
    assign suspend_o   = q.susp_pulse;
endmodule

// File: rtl/up_neg_checker.sv
module up_neg_checker (
    input logic clk,
    input logic rst_n,
    input logic chirp_k_o,
    input logic hs_term_o,
    input logic fs_pullup_o,
    input logic hs_mode_o,
    input logic bus_reset_o,
    input logic suspend_o
);
    AST_RESET_STARTS_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_o |-> chirp_k_o); // R2
    AST_CHIRP_ONLY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_k_o) |-> bus_reset_o); // R2
    AST_CHIRP_KEEPS_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k_o |-> fs_pullup_o); // R5
    AST_HS_ENTRY_FROM_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> ($past(fs_pullup_o) && !$past(chirp_k_o))); // R6
    AST_REVERT_TO_FS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode_o) |-> (fs_pullup_o && !chirp_k_o && !hs_term_o)); // R9
    AST_SUSPEND_IN_FS: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_o |-> (fs_pullup_o && !hs_mode_o && !chirp_k_o && !bus_reset_o)); // R10
    AST_TERM_PULLUP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_term_o && fs_pullup_o)); // R11
endmodule

bind up_speed_negotiator up_neg_checker u_neg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .chirp_k_o   (chirp_k_o),
    .hs_term_o   (hs_term_o),
    .fs_pullup_o (fs_pullup_o),
    .hs_mode_o   (hs_mode_o),
    .bus_reset_o (bus_reset_o),
    .suspend_o   (suspend_o)
);

// File: tb/tb_up_speed_negotiator.sv
module tb_up_speed_negotiator;
    import up_neg_pkg::*;

    localparam int AW = 100;
    localparam int SS = 3;
    localparam int RV = 3050;
    localparam int SM = 200;
    localparam int CH = 1500;
    localparam int FB = 2000;
    localparam int FT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_i = LN_J;
    logic       suspended_i = 1'b0;
    logic       tick_i = 1'b1;
    logic       chirp_k_o, hs_term_o, fs_pullup_o, hs_mode_o, bus_reset_o, suspend_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    up_speed_negotiator #(
        .AWAKE_RST_TICKS (AW), .SUSP_SE0_TICKS (SS), .REVERT_TICKS (RV),
        .SAMPLE_TICKS (SM), .CHIRP_TICKS (CH), .FALLBACK_TICKS (FB),
        .FILT_TICKS (FT), .CHIRP_PAIRS (3)
    ) dut (
        .clk (clk), .rst_n (rst_n), .line_i (line_i), .suspended_i (suspended_i),
        .tick_i (tick_i), .chirp_k_o (chirp_k_o), .hs_term_o (hs_term_o),
        .fs_pullup_o (fs_pullup_o), .hs_mode_o (hs_mode_o),
        .bus_reset_o (bus_reset_o), .suspend_o (suspend_o)
    );

    function automatic bit exp_chirp(input int len, input bit susp);
        return len >= (susp ? SS : AW);
    endfunction

    function automatic bit exp_hs(input int l0, input int l1, input int l2,
                                  input int l3, input int l4, input int l5);
        return (l0 >= FT) && (l1 >= FT) && (l2 >= FT) && (l3 >= FT) && (l4 >= FT) && (l5 >= FT);
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            line_i = v;
            @(negedge clk);
        end
    endtask

    task automatic host_pairs(input int l0, input int l1, input int l2,
                              input int l3, input int l4, input int l5);
        step(LN_K, l0); step(LN_J, l1);
        step(LN_K, l2); step(LN_J, l3);
        step(LN_K, l4); step(LN_J, l5);
    endtask

    task automatic finish_chirp;
        while (chirp_k_o) step(LN_J, 1);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(fs_pullup_o, 1, "R1 pullup");
        chk(hs_term_o, 0, "R1 term");
        chk(chirp_k_o, 0, "R1 chirp");
        chk(hs_mode_o, 0, "R1 hs");
        chk(bus_reset_o | suspend_o, 0, "R1 pulses");

        // R4 no tick, no progress
        tick_i = 1'b0;
        step(LN_SE0, 3 * AW);
        chk(chirp_k_o, 0, "R4 no tick");
        tick_i = 1'b1;
        step(LN_J, 1);

        // R2 boundary one short
        step(LN_SE0, AW - 1);
        step(LN_J, 1);
        chk(chirp_k_o, 0, "R2 short SE0");
        // R2 exact threshold
        step(LN_SE0, AW);
        chk(chirp_k_o, 1, "R2 chirp start");
        chk(bus_reset_o, 1, "R2 reset pulse");

        // R5 chirp length
        begin
            int n = 1;
            int pu_bad = 0;
            while (chirp_k_o) begin
                if (!fs_pullup_o) pu_bad++;
                step(LN_J, 1);
                if (chirp_k_o) n++;
            end
            chk(n, CH, "R5 chirp length");
            chk(pu_bad, 0, "R5 pullup during chirp");
        end

        // R6 three full pairs
        host_pairs(FT, FT, FT, FT, FT, FT);
        step(LN_J, 1);
        chk(hs_mode_o, 1, "R6 hs mode");
        chk(hs_term_o, 1, "R6 term");
        chk(fs_pullup_o, 0, "R6 pullup off");

        // R9 revert boundary
        step(LN_SE0, RV - 1);
        step(LN_J, 1);
        chk(hs_mode_o, 1, "R9 short SE0 in HS");
        step(LN_SE0, RV);
        chk(hs_mode_o, 0, "R9 reverted hs");
        chk(hs_term_o, 0, "R9 term off");
        chk(fs_pullup_o, 1, "R9 pullup on");
        // R10 suspend path
        step(LN_SE0, SM - 1);
        step(LN_J, 1);
        chk(suspend_o, 1, "R10 suspend pulse");
        chk(chirp_k_o, 0, "R10 no chirp on suspend");
        chk(bus_reset_o, 0, "R10 no reset on suspend");

        // back to HS, then R10 reset path
        step(LN_SE0, AW);
        finish_chirp();
        host_pairs(FT, FT, FT, FT, FT, FT);
        step(LN_J, 1);
        chk(hs_mode_o, 1, "R6 hs again");
        step(LN_SE0, RV + SM);
        chk(chirp_k_o, 1, "R10 chirp after sample");
        chk(bus_reset_o, 1, "R10 reset pulse");

        // R8 fallback and late chirps ignored
        finish_chirp();
        step(LN_J, FB + 5);
        chk(hs_mode_o, 0, "R8 fallback");
        chk(fs_pullup_o, 1, "R8 pullup");
        host_pairs(FT, FT, FT, FT, FT, FT);
        step(LN_J, 2);
        chk(hs_mode_o, 0, "R8 late chirps ignored");

        // R3 suspended threshold
        suspended_i = 1'b1;
        step(LN_SE0, SS - 1);
        step(LN_J, 1);
        chk(chirp_k_o, 0, "R3 short SE0 suspended");
        step(LN_SE0, SS);
        chk(chirp_k_o, 1, "R3 chirp suspended");
        suspended_i = 1'b0;

        // R7 short chirp rejected
        finish_chirp();
        host_pairs(FT - 1, FT, FT, FT, FT, FT);
        step(LN_J, 2);
        chk(hs_mode_o, 0, "R7 short chirp");
        step(LN_J, FB);

        // R2 R3 random SE0 runs
        for (int t = 0; t < 8; t++) begin
            bit s = 1'($urandom_range(0, 1));
            int thr = s ? SS : AW;
            int len = $urandom_range(1, 2 * thr);
            suspended_i = s;
            step(LN_SE0, len);
            step(LN_J, 1);
            chk(chirp_k_o, int'(exp_chirp(len, s)), s ? "R3 random SE0" : "R2 random SE0");
            suspended_i = 1'b0;
            if (chirp_k_o) begin
                finish_chirp();
                step(LN_J, FB + 2);
            end
            chk(hs_mode_o, 0, "R8 idle after trial");
        end

        // R6 R7 random chirp lengths
        for (int t = 0; t < 6; t++) begin
            int l[6];
            bit e;
            for (int i = 0; i < 6; i++)
                l[i] = ($urandom_range(0, 4) == 0) ? FT - 1 : $urandom_range(FT, FT + 2);
            e = exp_hs(l[0], l[1], l[2], l[3], l[4], l[5]);
            step(LN_SE0, AW);
            finish_chirp();
            host_pairs(l[0], l[1], l[2], l[3], l[4], l[5]);
            step(LN_J, 2);
            chk(hs_mode_o, int'(e), e ? "R6 random pairs" : "R7 random pairs");
            if (hs_mode_o) begin
                step(LN_SE0, RV + SM - 1);
                step(LN_J, 1);
                chk(suspend_o, 1, "R10 random suspend");
            end else begin
                step(LN_J, FB);
            end
        end

        finished = 1'b1;
        report();
    end
endmodule